// File: doc/BRIEF.md
# DMA Channel Control and Interrupt Register Block

This block is the register front end of a descriptor-driven DMA controller. A processor reaches it through a 32-bit, word-access bus. The bus address picks a channel and a register inside that channel's window.

Each channel holds the following registers:
- five descriptor pointers;
- a configuration word, which sets the channel's one-hot run state;
- a continue command;
- a stream command;
- an interrupt mask and a raw interrupt register, with a write-only acknowledge.

The transfer engine sits beside the block. It receives continue and stream commands as single-cycle pulses. It reports its end-of-list flag and its stream-command source, and both appear live in the status word. It raises raw interrupt bits through one-cycle set pulses. Each channel drives one level interrupt line, which is the OR of its unmasked raw bits.

Top module: `dma_chan_ctrl_regs`

## Requirements
- R1: Address bits 13 and up select the channel, and bits [7:2] select the register word. Bits [12:8] are ignored, so an address with those bits set reaches the same register.
- R2: The pointer registers hold a full 32-bit value written and read back unchanged. Their byte offsets are: current descriptor 0x00, saved data 0x58, saved buffer 0x5C, group 0x60, group-down 0x7C.
- R3: The run state is one-hot: reset = 3'b001, stopped = 3'b010, running = 3'b100. After reset every channel is in the reset state. An engine start pulse moves a channel to running.
- R4: A write to the config register (0x84) with bit 1 set forces stopped. A write with bit 0 clear forces reset, and this wins over bit 1. A write of 2'b01 leaves the state unchanged.
- R5: A status read (0x88) returns the run state in [2:0], the live end-of-list flag in bit 5 and the live stream source in [9:8]. All other bits read 0.
- R6: A write to the acknowledge register (0x90) clears the written bits from the raw interrupt register (0x94). Acknowledge always reads 0. The masked register (0x98) reads raw AND mask (mask at 0x8C). The channel's irq line is the OR of the masked bits.
- R7: A raw interrupt bit that receives a set pulse and an acknowledge in the same cycle ends up set.
- R8: An access whose byte enables are not all set, or whose address bits [1:0] are not zero, raises bus_err for one cycle. It changes no register and returns no read data.
- R9: A write to the command register (0x80) keeps only bit 0. When bit 0 is 1 it gives a one-cycle cont_pulse for that channel. Any other set bit raises bad_value for one cycle.
- R10: A write to the stream register (0x9C) keeps bits [9:0], gives a one-cycle strm_pulse and presents the kept bits on strm_cmd. Set bits above bit 9 raise bad_value.
- R11: After reset every readable register of every channel reads 0, except status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 13+CH_W | Byte address |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read |
| bus_err | output | 1 | Narrow or misaligned access pulse |
| bad_value | output | 1 | Illegal bits in a command or stream write |
| eng_start | input | NUM_CH | Engine start pulse per channel |
| eng_eol | input | NUM_CH | End-of-list flag per channel |
| eng_src | input | NUM_CH*SRC_W | Stream-command source per channel |
| intr_set | input | NUM_CH*IRQ_W | Raw interrupt set pulses |
| cont_pulse | output | NUM_CH | Continue pulse per channel |
| strm_pulse | output | NUM_CH | Stream-command pulse per channel |
| strm_cmd | output | NUM_CH*10 | Stored stream command per channel |
| run_state | output | NUM_CH*3 | One-hot run state per channel |
| irq | output | NUM_CH | Level interrupt per channel |

## Verification
The config word is tried with all four values of its low two bits, from both the running and the stopped state. This separates the stop-forcing path from the reset-forcing path and shows that reset has priority over stop.

For interrupts, separate set, mask and acknowledge sequences are each compared against raw, masked and irq. A separate test runs a set and an acknowledge of the same bit in one cycle, which shows whether set or clear takes priority.

Aliased addresses and a second channel at the same offset check that bits [12:8] are ignored and that the channel bits do select. Narrow and misaligned accesses, and command and stream writes with stray upper bits, tell the access that is dropped apart from the access that is stored but flagged.

// File: rtl/dma_regs_pkg.sv
// Package: shared word indices and run-state encoding for the DMA register block.
// Assumes byte offsets inside a channel window are word aligned.
package dma_regs_pkg;
    localparam int WIN_BITS = 13;           // 0x2000-byte window per channel

    localparam logic [5:0] W_DESC   = 6'h00; // 0x00
    localparam logic [5:0] W_SDATA  = 6'h16; // 0x58
    localparam logic [5:0] W_SBUF   = 6'h17; // 0x5C
    localparam logic [5:0] W_GRP    = 6'h18; // 0x60
    localparam logic [5:0] W_GDOWN  = 6'h1F; // 0x7C
    localparam logic [5:0] W_CMD    = 6'h20; // 0x80
    localparam logic [5:0] W_CFG    = 6'h21; // 0x84
    localparam logic [5:0] W_STAT   = 6'h22; // 0x88
    localparam logic [5:0] W_MASK   = 6'h23; // 0x8C
    localparam logic [5:0] W_ACK    = 6'h24; // 0x90
    localparam logic [5:0] W_RAW    = 6'h25; // 0x94
    localparam logic [5:0] W_MSKD   = 6'h26; // 0x98
    localparam logic [5:0] W_STRM   = 6'h27; // 0x9C

    localparam int STRM_W = 10;

    typedef enum logic [2:0] {
        ST_RST  = 3'b001,
        ST_STOP = 3'b010,
        ST_RUN  = 3'b100
    } run_state_t;
endpackage

// File: rtl/dma_addr_dec.sv
// Module: dma_addr_dec
// Splits a bus address into channel index and register word and qualifies the strobes.
// Assumes only full aligned 32-bit accesses are legal; bits [12:8] are don't-care.
module dma_addr_dec #(
    parameter int NUM_CH = 2,
    parameter int CH_W   = 1,
    localparam int AW    = dma_regs_pkg::WIN_BITS + CH_W
) (
    input  logic            wr,
    input  logic            rd,
    input  logic [AW-1:0]   addr,
    input  logic [3:0]      be,
    output logic [CH_W-1:0] ch_idx,
    output logic            ch_hit,
    output logic [5:0]      word,
    output logic            wr_ok,
    output logic            rd_ok,
    output logic            narrow
);
    logic full;
    logic unused_alias;

    // Address split and access qualification.
    always_comb begin
        ch_idx = addr[AW-1:dma_regs_pkg::WIN_BITS];
        ch_hit = (int'(ch_idx) < NUM_CH);
        word   = addr[7:2];
        full   = (be == 4'hF) && (addr[1:0] == 2'b00);
        wr_ok  = wr && full && ch_hit;
        rd_ok  = rd && full && ch_hit;
        narrow = (wr || rd) && !full;
    end

    assign unused_alias = ^addr[dma_regs_pkg::WIN_BITS-1:8];
endmodule

// File: rtl/dma_irq_unit.sv
// Module: dma_irq_unit
// Raw interrupt bits, mask and level output for one channel.
// Assumes set pulses last one cycle; a set beats a same-cycle acknowledge.
module dma_irq_unit #(
    parameter int IRQ_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_we,
    input  logic             mask_we,
    input  logic [IRQ_W-1:0] wval,
    input  logic [IRQ_W-1:0] set,
    output logic [IRQ_W-1:0] raw,
    output logic [IRQ_W-1:0] mask,
    output logic [IRQ_W-1:0] masked,
    output logic             irq
);
    logic [IRQ_W-1:0] clr;

    // Bits removed by an acknowledge write this cycle.
    assign clr = ack_we ? wval : '0;

    // Raw and mask storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raw  <= '0;
            mask <= '0;
        end else begin
            raw <= (raw & ~clr) | set;
            if (mask_we) mask <= wval;
        end
    end

    // Masked view and level line.
    assign masked = raw & mask;
    assign irq    = |masked;

    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_we && set == '0) |=> ((raw & $past(wval)) == '0)); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (set != '0) |=> ((raw & $past(set)) == $past(set))); // R7
endmodule

// File: rtl/dma_chan_regs.sv
// Module: dma_chan_regs
// All registers of one DMA channel: pointers, config/run state, command,
// stream command and interrupts. Presents the selected word combinationally.
// Assumes wr_en is already qualified for full access and channel match.
module dma_chan_regs #(
    parameter int IRQ_W = 4,
    parameter int SRC_W = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [5:0]                     word,
    input  logic [31:0]                    wdata,
    input  logic                           start,
    input  logic                           eol,
    input  logic [SRC_W-1:0]               src,
    input  logic [IRQ_W-1:0]               set,
    output logic [31:0]                    rd_word,
    output logic                           cont_pulse,
    output logic                           strm_pulse,
    output logic [dma_regs_pkg::STRM_W-1:0] strm_cmd,
    output logic [2:0]                     state,
    output logic                           irq,
    output logic                           bad
);
    import dma_regs_pkg::*;

    localparam int NPTR = 5;

    logic [31:0]      ptr [NPTR];
    logic             cmd_q;
    logic [1:0]       cfg_q;
    run_state_t       st_q;
    logic [IRQ_W-1:0] raw, mask, masked;
    logic             we_cfg, we_cmd, we_strm, we_ack, we_mask;

    // Write strobes per register.
    always_comb begin
        we_cfg  = wr_en && (word == W_CFG);
        we_cmd  = wr_en && (word == W_CMD);
        we_strm = wr_en && (word == W_STRM);
        we_ack  = wr_en && (word == W_ACK);
        we_mask = wr_en && (word == W_MASK);
        bad     = (we_cmd && (wdata[31:1] != '0)) ||
                  (we_strm && (wdata[31:STRM_W] != '0));
    end

    // Pointer registers, one per mapped word.
    for (genvar p = 0; p < NPTR; p++) begin : g_ptr
        localparam logic [5:0] PW = (p == 0) ? W_DESC  :
                                    (p == 1) ? W_SDATA :
                                    (p == 2) ? W_SBUF  :
                                    (p == 3) ? W_GRP   : W_GDOWN;
        // Holds one descriptor pointer.
        always_ff @(posedge clk) begin
            if (!rst_n)                     ptr[p] <= '0;
            else if (wr_en && word == PW)   ptr[p] <= wdata;
        end
    end

    // Command, config and stream registers with their engine pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q      <= 1'b0;
            cfg_q      <= 2'b00;
            strm_cmd   <= '0;
            cont_pulse <= 1'b0;
            strm_pulse <= 1'b0;
        end else begin
            cont_pulse <= we_cmd && wdata[0];
            strm_pulse <= we_strm;
            if (we_cmd)  cmd_q    <= wdata[0];
            if (we_cfg)  cfg_q    <= wdata[1:0];
            if (we_strm) strm_cmd <= wdata[STRM_W-1:0];
        end
    end

    // Run state: config write forces stop/reset (reset last), else engine start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_RST;
        end else if (we_cfg) begin
            if (wdata[1])  st_q <= ST_STOP;
            if (!wdata[0]) st_q <= ST_RST;
        end else if (start) begin
            st_q <= ST_RUN;
        end
    end

    assign state = st_q;

    dma_irq_unit #(.IRQ_W(IRQ_W)) i_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .ack_we (we_ack),
        .mask_we(we_mask),
        .wval   (wdata[IRQ_W-1:0]),
        .set    (set),
        .raw    (raw),
        .mask   (mask),
        .masked (masked),
        .irq    (irq)
    );

    // Read view of the addressed word.
    always_comb begin
        rd_word = '0;
        case (word)
            W_DESC:  rd_word = ptr[0];
            W_SDATA: rd_word = ptr[1];
            W_SBUF:  rd_word = ptr[2];
            W_GRP:   rd_word = ptr[3];
            W_GDOWN: rd_word = ptr[4];
            W_CMD:   rd_word = {31'd0, cmd_q};
            W_CFG:   rd_word = {30'd0, cfg_q};
            W_STAT: begin
                rd_word[2:0]           = st_q;
                rd_word[5]             = eol;
                rd_word[8 +: SRC_W]    = src;
            end
            W_MASK:  rd_word[IRQ_W-1:0] = mask;
            W_RAW:   rd_word[IRQ_W-1:0] = raw;
            W_MSKD:  rd_word[IRQ_W-1:0] = masked;
            W_STRM:  rd_word[STRM_W-1:0] = strm_cmd;
            default: rd_word = '0;
        endcase
    end

    AST_STATE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(state) == 1); // R3
    AST_CFG_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (we_cfg && !wdata[0]) |=> (state == ST_RST)); // R4
    AST_CONT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        cont_pulse |-> $past(we_cmd)); // R9
endmodule

// File: rtl/dma_chan_ctrl_regs.sv
// Module: dma_chan_ctrl_regs (top)
// Multi-channel DMA control/interrupt register block on a 32-bit word bus.
// Reads return data one cycle after the strobe; illegal accesses pulse bus_err.
// Assumes read and write strobes are not issued in the same cycle.
module dma_chan_ctrl_regs #(
    parameter int NUM_CH = 2,
    parameter int IRQ_W  = 4,
    parameter int SRC_W  = 2,
    parameter int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [13+CH_W-1:0]         bus_addr,
    input  logic [3:0]                 bus_be,
    input  logic [31:0]                bus_wdata,
    output logic [31:0]                bus_rdata,
    output logic                       bus_rvalid,
    output logic                       bus_err,
    output logic                       bad_value,
    input  logic [NUM_CH-1:0]          eng_start,
    input  logic [NUM_CH-1:0]          eng_eol,
    input  logic [NUM_CH*SRC_W-1:0]    eng_src,
    input  logic [NUM_CH*IRQ_W-1:0]    intr_set,
    output logic [NUM_CH-1:0]          cont_pulse,
    output logic [NUM_CH-1:0]          strm_pulse,
    output logic [NUM_CH*10-1:0]       strm_cmd,
    output logic [NUM_CH*3-1:0]        run_state,
    output logic [NUM_CH-1:0]          irq
);
    logic [CH_W-1:0]   ch_idx;
    logic              ch_hit;
    logic [5:0]        word;
    logic              wr_ok, rd_ok, narrow;
    logic [31:0]       rd_all [NUM_CH];
    logic [NUM_CH-1:0] bad_ch;
    logic [31:0]       rd_sel;

    dma_addr_dec #(.NUM_CH(NUM_CH), .CH_W(CH_W)) i_dec (
        .wr    (bus_wr),
        .rd    (bus_rd),
        .addr  (bus_addr),
        .be    (bus_be),
        .ch_idx(ch_idx),
        .ch_hit(ch_hit),
        .word  (word),
        .wr_ok (wr_ok),
        .rd_ok (rd_ok),
        .narrow(narrow)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dma_chan_regs #(.IRQ_W(IRQ_W), .SRC_W(SRC_W)) i_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .wr_en     (wr_ok && (int'(ch_idx) == c)),
            .word      (word),
            .wdata     (bus_wdata),
            .start     (eng_start[c]),
            .eol       (eng_eol[c]),
            .src       (eng_src[c*SRC_W +: SRC_W]),
            .set       (intr_set[c*IRQ_W +: IRQ_W]),
            .rd_word   (rd_all[c]),
            .cont_pulse(cont_pulse[c]),
            .strm_pulse(strm_pulse[c]),
            .strm_cmd  (strm_cmd[c*10 +: 10]),
            .state     (run_state[c*3 +: 3]),
            .irq       (irq[c]),
            .bad       (bad_ch[c])
        );
    end

    // Channel read select.
    always_comb begin
        rd_sel = '0;
        for (int c = 0; c < NUM_CH; c++)
            if (ch_hit && int'(ch_idx) == c) rd_sel = rd_all[c];
    end

    // Registered bus response and error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            bus_err    <= 1'b0;
            bad_value  <= 1'b0;
        end else begin
            bus_rvalid <= rd_ok;
            bus_err    <= narrow;
            bad_value  <= |bad_ch;
            if (rd_ok) bus_rdata <= rd_sel;
        end
    end

    AST_NARROW_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_be != 4'hF && eng_start == '0) |=> $stable(run_state)); // R8
    AST_NARROW_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_be != 4'hF) |=> (bus_err && !bus_rvalid)); // R8
endmodule

// File: tb/test_dma_chan_ctrl_regs.sv
`timescale 1ns/1ps
module test_dma_chan_ctrl_regs;
    localparam int NUM_CH = 2;
    localparam int IRQ_W  = 4;
    localparam int SRC_W  = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr, bus_rd;
    logic [13:0] bus_addr;
    logic [3:0]  bus_be;
    logic [31:0] bus_wdata, bus_rdata;
    logic        bus_rvalid, bus_err, bad_value;
    logic [NUM_CH-1:0] eng_start, eng_eol, cont_pulse, strm_pulse, irq;
    logic [NUM_CH*SRC_W-1:0] eng_src;
    logic [NUM_CH*IRQ_W-1:0] intr_set;
    logic [NUM_CH*10-1:0] strm_cmd;
    logic [NUM_CH*3-1:0]  run_state;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rv;

    always #5 clk = ~clk;

    dma_chan_ctrl_regs #(.NUM_CH(NUM_CH), .IRQ_W(IRQ_W), .SRC_W(SRC_W)) i_dma_chan_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .bus_err(bus_err),
        .bad_value(bad_value), .eng_start(eng_start), .eng_eol(eng_eol),
        .eng_src(eng_src), .intr_set(intr_set), .cont_pulse(cont_pulse),
        .strm_pulse(strm_pulse), .strm_cmd(strm_cmd), .run_state(run_state), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [13:0] a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = 4'hF;
    endtask

    task automatic rd(input logic [13:0] a, output logic [31:0] d, input logic [3:0] be = 4'hF);
        bus_rd = 1'b1; bus_addr = a; bus_be = be;
        @(negedge clk);
        d = bus_rdata;
        bus_rd = 1'b0; bus_be = 4'hF;
    endtask

    task automatic chk_rd(input logic [13:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] d;
        rd(a, d);
        check(bus_rvalid && d == exp, tag, d, exp);
    endtask

    task automatic t_reset();
        check(run_state == 6'b001_001, "R3 reset state", 32'(run_state), 32'h9);
        chk_rd(14'h0058, 0, "R11 sdata reset");
        chk_rd(14'h2094, 0, "R11 raw reset");
        chk_rd(14'h009C, 0, "R11 stream reset");
        chk_rd(14'h0084, 0, "R11 cfg reset");
        check(irq == 0, "R11 irq reset", 32'(irq), 0);
    endtask

    task automatic t_pointers();
        wr(14'h0000, 32'hDEAD_0000); wr(14'h0058, 32'h1111_2222);
        wr(14'h005C, 32'h3333_4444); wr(14'h0060, 32'h5555_6666);
        wr(14'h007C, 32'h7777_8888); wr(14'h2058, 32'hCAFE_F00D);
        chk_rd(14'h0000, 32'hDEAD_0000, "R2 desc");
        chk_rd(14'h0058, 32'h1111_2222, "R2 sdata");
        chk_rd(14'h005C, 32'h3333_4444, "R2 sbuf");
        chk_rd(14'h0060, 32'h5555_6666, "R2 group");
        chk_rd(14'h007C, 32'h7777_8888, "R2 gdown");
        chk_rd(14'h2058, 32'hCAFE_F00D, "R1 channel 1 distinct");
    endtask

    task automatic t_alias();
        wr(14'h1F5C, 32'hA5A5_0001);
        chk_rd(14'h005C, 32'hA5A5_0001, "R1 alias write");
        chk_rd(14'h1A5C, 32'hA5A5_0001, "R1 alias read");
    endtask

    task automatic t_cfg_state();
        eng_start = 2'b01; @(negedge clk); eng_start = 0;
        check(run_state[2:0] == 3'b100, "R3 start running", 32'(run_state[2:0]), 4);
        wr(14'h0084, 32'h1);
        check(run_state[2:0] == 3'b100, "R4 cfg 01 keeps", 32'(run_state[2:0]), 4);
        wr(14'h0084, 32'h3);
        check(run_state[2:0] == 3'b010, "R4 cfg 11 stops", 32'(run_state[2:0]), 2);
        wr(14'h0084, 32'h2);
        check(run_state[2:0] == 3'b001, "R4 cfg 10 reset wins", 32'(run_state[2:0]), 1);
        eng_start = 2'b01; @(negedge clk); eng_start = 0;
        wr(14'h0084, 32'h0);
        check(run_state[2:0] == 3'b001, "R4 cfg 00 resets", 32'(run_state[2:0]), 1);
        check(run_state[5:3] == 3'b001, "R4 other channel untouched", 32'(run_state[5:3]), 1);
        chk_rd(14'h0084, 32'h0, "R4 cfg readback");
    endtask

    task automatic t_status();
        eng_start = 2'b10; @(negedge clk); eng_start = 0;
        eng_eol = 2'b10; eng_src = 4'b10_00;
        chk_rd(14'h2088, 32'h0000_0224, "R5 status ch1");
        chk_rd(14'h0088, 32'h0000_0001, "R5 status ch0");
        eng_eol = 0; eng_src = 0;
        chk_rd(14'h2088, 32'h0000_0004, "R5 status live");
    endtask

    task automatic t_irq();
        intr_set = 8'h0B; @(negedge clk); intr_set = 0;
        chk_rd(14'h0094, 32'hB, "R6 raw set");
        check(irq[0] == 1'b0, "R6 irq masked off", 32'(irq[0]), 0);
        wr(14'h008C, 32'h4);
        check(irq[0] == 1'b0, "R6 mask no overlap", 32'(irq[0]), 0);
        wr(14'h008C, 32'h8);
        check(irq[0] == 1'b1, "R6 irq on", 32'(irq[0]), 1);
        chk_rd(14'h0098, 32'h8, "R6 masked reg");
        wr(14'h0090, 32'h8);
        check(irq[0] == 1'b0, "R6 ack drops irq", 32'(irq[0]), 0);
        chk_rd(14'h0094, 32'h3, "R6 raw after ack");
        chk_rd(14'h0090, 32'h0, "R6 ack reads zero");
    endtask

    task automatic t_set_wins();
        bus_wr = 1'b1; bus_addr = 14'h0090; bus_wdata = 32'h3; intr_set = 8'h02;
        @(negedge clk);
        bus_wr = 1'b0; intr_set = 0;
        chk_rd(14'h0094, 32'h2, "R7 set beats ack");
    endtask

    task automatic t_narrow();
        wr(14'h0058, 32'h0BAD_0BAD, 4'h3);
        check(bus_err == 1'b1, "R8 narrow write err", 32'(bus_err), 1);
        wr(14'h005A, 32'h0BAD_0BAD);
        check(bus_err == 1'b1, "R8 misaligned err", 32'(bus_err), 1);
        chk_rd(14'h0058, 32'h1111_2222, "R8 no effect");
        check(bus_err == 1'b0, "R8 legal no err", 32'(bus_err), 0);
        rd(14'h0058, rv, 4'h1);
        check(bus_err && !bus_rvalid, "R8 narrow read", {30'd0, bus_err, bus_rvalid}, 32'h2);
        wr(14'h0084, 32'h3, 4'h1);
        check(run_state[2:0] == 3'b001, "R8 cfg narrow ignored", 32'(run_state[2:0]), 1);
    endtask

    task automatic t_cmd();
        wr(14'h0080, 32'h1);
        check(cont_pulse == 2'b01 && !bad_value, "R9 continue pulse", {30'd0, cont_pulse}, 1);
        @(negedge clk);
        check(cont_pulse == 2'b00, "R9 pulse one cycle", 32'(cont_pulse), 0);
        wr(14'h2080, 32'h0000_0101);
        check(cont_pulse == 2'b10 && bad_value, "R9 flagged and pulsed", {29'd0, bad_value, cont_pulse}, 32'h6);
        chk_rd(14'h2080, 32'h1, "R9 only bit0 kept");
        wr(14'h0080, 32'h0);
        check(cont_pulse == 0 && !bad_value, "R9 no pulse for 0", {29'd0, bad_value, cont_pulse}, 0);
    endtask

    task automatic t_stream();
        wr(14'h009C, 32'h0000_0240);
        check(strm_pulse == 2'b01 && strm_cmd[9:0] == 10'h240 && !bad_value, "R10 stream",
              {strm_pulse, bad_value, 19'd0, strm_cmd[9:0]}, {2'b01, 1'b0, 19'd0, 10'h240});
        @(negedge clk);
        check(strm_pulse == 0, "R10 pulse one cycle", 32'(strm_pulse), 0);
        wr(14'h209C, 32'hFFFF_F3C0);
        check(bad_value && strm_cmd[19:10] == 10'h3C0, "R10 truncate flag",
              {bad_value, 21'd0, strm_cmd[19:10]}, {1'b1, 21'd0, 10'h3C0});
        chk_rd(14'h209C, 32'h3C0, "R10 readback");
    endtask

    initial begin
        #1_000_000;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; bus_wr = 0; bus_rd = 0; bus_addr = 0; bus_be = 4'hF; bus_wdata = 0;
        eng_start = 0; eng_eol = 0; eng_src = 0; intr_set = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_pointers();
        t_alias();
        t_cfg_state();
        t_status();
        t_irq();
        t_set_wins();
        t_narrow();
        t_cmd();
        t_stream();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule